// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Hidden and Forced Refresh

This block decides when a dynamic RAM array is refreshed. The RAM is shared between a local processor and an external bus master. A periodic tick opens each refresh interval and leaves one refresh owed. The scheduler first tries to hide that refresh inside a processor cycle that is aimed at some other memory or I/O. It recognises such a cycle as an address strobe seen while the RAM chip select is low.

If the interval ends with the refresh still owed, the next tick escalates it. This happens because every strobe hit RAM, because no strobe came at all (for example during off-board cycles), or because the external master held the RAM. On escalation the block raises a bus request, waits for the grant and for the external port to go idle, and then runs a forced refresh of fixed length. An external access that stays open too long while a refresh is owed is cut off through an abort output, and a configuration input can switch this off. A row counter steps once per completed refresh.

Strobe timing and RAS/CAS generation lie outside the block. It only decides when a refresh runs and which row is next.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `ref_active_o`, `bus_req_o` and `ext_abort_o` are 0 and `row_o` is 0.
- R2: A tick makes one refresh owed. While one is owed and the scheduler is idle, a strobe with `ram_cs_i`=0 and `ext_req_i`=0 starts a hidden refresh. `ref_active_o` rises on the next cycle and stays high for exactly REF_CYC cycles, with `bus_req_o` kept at 0.
- R3: A strobe that arrives with `ram_cs_i`=1 does not start a refresh.
- R4: With no refresh owed, strobes have no effect on `ref_active_o` or `bus_req_o`.
- R5: A tick that arrives while a refresh is still owed and the scheduler is idle raises `bus_req_o` on the next cycle. The request then stays high, with no refresh, until `bus_grant_i` is seen.
- R6: A forced refresh starts the cycle after `bus_grant_i`=1 is sampled with `ext_req_i`=0 and lasts REF_CYC cycles. `bus_req_o` and `ref_active_o` fall on the same clock edge.
- R7: `row_o` (ROW_W bits) increases by one at the edge that ends each hidden or forced refresh, wrapping from all ones to 0, and holds otherwise.
- R8: At most one refresh is owed besides the one being escalated. Extra ticks arriving while one is owed are dropped and produce no extra refresh.
- R9: With `tmo_en_i`=1 and a refresh owed, `ext_abort_o` goes high after `ext_req_i` has been high for EXT_TMO+1 consecutive clock edges. It stays high while `ext_req_i` stays high, and it falls one cycle after `ext_req_i` drops.
- R10: `ext_abort_o` stays 0 when `tmo_en_i`=0 or when no refresh is owed, however long `ext_req_i` is held.
- R11: No refresh, hidden or forced, starts while `ext_req_i` is high.
- R12: Once `bus_req_o` is high, a strobe with `ram_cs_i`=0 does not start a hidden refresh; only the forced path serves the owed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse opening a refresh interval |
| as_i | input | 1 | Processor address strobe, one cycle per access |
| ram_cs_i | input | 1 | RAM chip select, sampled with the strobe |
| ext_req_i | input | 1 | External master has a RAM access open |
| bus_grant_i | input | 1 | Processor has released the bus |
| tmo_en_i | input | 1 | Enables the external-access timeout |
| ref_active_o | output | 1 | A refresh cycle is running |
| bus_req_o | output | 1 | Request for the processor bus for a forced refresh |
| ext_abort_o | output | 1 | Cut off the open external access |
| row_o | output | ROW_W | Next row to refresh |

## Verification
Every result is registered once. A strobe, tick or grant sampled at one edge shows on `ref_active_o` or `bus_req_o` right after that edge. A refresh ends REF_CYC edges later, and `row_o` steps at that same edge. The abort flag appears after the (EXT_TMO+1)-th edge of a held external request, and it clears one edge after the request drops. The bench drives inputs just after a rising edge and samples just after the next. It sweeps the edge index across the refresh length, the timeout window and several strobe delays, and compares each sample with the cycle count worked out from these latencies.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_HIDE  = 2'd1,
      RS_WAIT  = 2'd2,
      RS_FORCE = 2'd3
   } rs_state_e;

endpackage

// File: rtl/rfs_engine.sv
module rfs_engine
   import refsched_pkg::*;
#(
   parameter int REF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic as_i,
   input  logic ram_cs_i,
   input  logic ext_busy_i,
   input  logic bus_grant_i,
   output logic ref_active_o,
   output logic bus_req_o,
   output logic owe_o,
   output logic done_o
);

   localparam int CW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(REF_CYC - 1);

   if (REF_CYC < 1) begin : g_bad_len
      $error("rfs_engine: REF_CYC must be at least 1");
   end

   rs_state_e      st_q, st_d;
   logic           pend_q, pend_d;
   logic [CW-1:0]  cnt_q, cnt_d;
   logic           spare_slot;

   // a strobe aimed elsewhere, with the external port quiet, can hide a refresh
   assign spare_slot = as_i & ~ram_cs_i & ~ext_busy_i;

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q | tick_i;
      cnt_d  = cnt_q;
      unique case (st_q)
         RS_IDLE: begin
            if (pend_q && spare_slot) begin
               st_d   = RS_HIDE;
               cnt_d  = LAST;
               pend_d = tick_i;
            end else if (pend_q && tick_i) begin
               // interval closed with the refresh still owed: escalate, drop new tick
               st_d   = RS_WAIT;
               pend_d = 1'b0;
            end
         end
         RS_WAIT: begin
            if (bus_grant_i && !ext_busy_i) begin
               st_d  = RS_FORCE;
               cnt_d = LAST;
            end
         end
         default: begin
            if (cnt_q == '0) begin
               st_d = RS_IDLE;
            end else begin
               cnt_d = cnt_q - CW'(1);
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RS_IDLE;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         cnt_q  <= cnt_d;
      end
   end

   assign ref_active_o = (st_q == RS_HIDE) || (st_q == RS_FORCE);
   assign bus_req_o    = (st_q == RS_WAIT) || (st_q == RS_FORCE);
   assign owe_o        = pend_q || (st_q == RS_WAIT);
   assign done_o       = ref_active_o && (cnt_q == '0);

   // R3: without a spare strobe an idle engine starts no hidden refresh
   a_r3_ram_hit_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RS_IDLE && !(as_i && !ram_cs_i)) |=> !ref_active_o);

   // R11: external port busy blocks any refresh start
   a_r11_ext_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_active_o && ext_busy_i) |=> !ref_active_o);

   // R5 / R12: pending request holds and no refresh runs until the grant
   a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !ref_active_o && !bus_grant_i) |=> (bus_req_o && !ref_active_o));

   // R6: request and refresh end together
   a_r6_end_together: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && ref_active_o) |=> (bus_req_o == ref_active_o));

   // R2: a refresh that starts without a bus request came from a spare strobe
   a_r2_hidden_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ref_active_o) && !bus_req_o) |-> $past(as_i && !ram_cs_i));

endmodule

// File: rtl/rfs_ext_guard.sv
module rfs_ext_guard #(
   parameter int EXT_TMO = 8,
   parameter bit HAS_TMO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_req_i,
   input  logic tmo_en_i,
   input  logic owe_i,
   output logic ext_abort_o
);

   if (EXT_TMO < 1) begin : g_bad_tmo
      $error("rfs_ext_guard: EXT_TMO must be at least 1");
   end

   if (HAS_TMO) begin : g_tmo
      localparam int TW = $clog2(EXT_TMO + 1);
      localparam logic [TW-1:0] LIMIT = TW'(EXT_TMO);

      logic [TW-1:0] age_q;
      logic          abort_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q   <= '0;
            abort_q <= 1'b0;
         end else begin
            if (!ext_req_i) begin
               age_q <= '0;
            end else if (age_q != LIMIT) begin
               age_q <= age_q + TW'(1);
            end
            abort_q <= tmo_en_i && ext_req_i && owe_i && (age_q == LIMIT);
         end
      end

      assign ext_abort_o = abort_q;

      // R10: abort only when enabled and a refresh is owed
      a_r10_abort_gated: assert property (@(posedge clk) disable iff (!rst_n)
         ext_abort_o |-> $past(tmo_en_i && owe_i));

      // R9: a freshly opened access is never aborted at once
      a_r9_no_early_abort: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ext_req_i) |=> !ext_abort_o);
   end else begin : g_none
      logic unused_guard;
      assign unused_guard = ^{clk, rst_n, ext_req_i, tmo_en_i, owe_i};
      assign ext_abort_o  = 1'b0;
   end

endmodule

// File: rtl/rfs_row_count.sv
module rfs_row_count #(
   parameter int ROW_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [ROW_W-1:0] row_o
);

   if (ROW_W < 1) begin : g_bad_w
      $error("rfs_row_count: ROW_W must be at least 1");
   end

   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (step_i) begin
         row_q <= row_q + ROW_W'(1);
      end
   end

   assign row_o = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int REF_CYC = 4,
   parameter int EXT_TMO = 8,
   parameter int ROW_W   = 7,
   parameter bit HAS_TMO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             as_i,
   input  logic             ram_cs_i,
   input  logic             ext_req_i,
   input  logic             bus_grant_i,
   input  logic             tmo_en_i,
   output logic             ref_active_o,
   output logic             bus_req_o,
   output logic             ext_abort_o,
   output logic [ROW_W-1:0] row_o
);

   logic owe;
   logic done;

   rfs_engine #(
      .REF_CYC (REF_CYC)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .as_i         (as_i),
      .ram_cs_i     (ram_cs_i),
      .ext_busy_i   (ext_req_i),
      .bus_grant_i  (bus_grant_i),
      .ref_active_o (ref_active_o),
      .bus_req_o    (bus_req_o),
      .owe_o        (owe),
      .done_o       (done)
   );

   rfs_ext_guard #(
      .EXT_TMO (EXT_TMO),
      .HAS_TMO (HAS_TMO)
   ) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_req_i   (ext_req_i),
      .tmo_en_i    (tmo_en_i),
      .owe_i       (owe),
      .ext_abort_o (ext_abort_o)
   );

   rfs_row_count #(
      .ROW_W (ROW_W)
   ) u_rows (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (done),
      .row_o  (row_o)
   );

   // R7: each finished refresh moves the row pointer by one
   a_r7_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_active_o) |-> (row_o == $past(row_o) + ROW_W'(1)));

   // R7: row pointer holds while a refresh is neither running nor ending
   a_r7_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_active_o |=> $stable(row_o));

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;

   localparam int RC  = 4;
   localparam int TMO = 8;
   localparam int RW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          as_s = 1'b0;
   logic          cs_s = 1'b0;
   logic          ext = 1'b0;
   logic          grant = 1'b0;
   logic          tmo_en = 1'b1;
   logic          active;
   logic          breq;
   logic          abort;
   logic [RW-1:0] row;

   int n_run  = 0;
   int n_fail = 0;
   int exp_row = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   dram_refresh_sched #(
      .REF_CYC (RC),
      .EXT_TMO (TMO),
      .ROW_W   (RW),
      .HAS_TMO (1'b1)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .as_i         (as_s),
      .ram_cs_i     (cs_s),
      .ext_req_i    (ext),
      .bus_grant_i  (grant),
      .tmo_en_i     (tmo_en),
      .ref_active_o (active),
      .bus_req_o    (breq),
      .ext_abort_o  (abort),
      .row_o        (row)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      step();
      tick = 1'b0;
   endtask

   task automatic strobe(input bit sel);
      as_s = 1'b1;
      cs_s = sel;
      step();
      as_s = 1'b0;
      cs_s = 1'b0;
   endtask

   // R2 / R7: one hidden refresh from a spare strobe, length and row step checked
   task automatic hidden_run(input string tag);
      strobe(1'b0);
      for (int c = 0; c <= RC; c++) begin
         chk(tag, "R2 ref_active", int'(active), (c < RC) ? 1 : 0);
         chk(tag, "R2 bus_req", int'(breq), 0);
         if (c < RC) step();
      end
      exp_row = (exp_row + 1) % (1 << RW);
      chk(tag, "R7 row", int'(row), exp_row);
   endtask

   initial begin
      // R1: reset state
      repeat (3) step();
      chk("R1", "active in reset", int'(active), 0);
      chk("R1", "bus_req in reset", int'(breq), 0);
      chk("R1", "abort in reset", int'(abort), 0);
      rst_n = 1'b1;
      step();
      chk("R1", "active after reset", int'(active), 0);
      chk("R1", "bus_req after reset", int'(breq), 0);
      chk("R1", "row after reset", int'(row), 0);

      // R4: strobes with nothing owed
      for (int i = 0; i < 3; i++) begin
         strobe(1'b0);
         chk("R4", "active no pending", int'(active), 0);
         chk("R4", "bus_req no pending", int'(breq), 0);
      end

      // R2: basic hidden refresh
      pulse_tick();
      step();
      hidden_run("R2");

      // R3: RAM-hit strobes do not refresh, then a spare one does
      pulse_tick();
      for (int i = 0; i < 4; i++) begin
         strobe(1'b1);
         chk("R3", "active on ram hit", int'(active), 0);
         chk("R3", "bus_req on ram hit", int'(breq), 0);
      end
      hidden_run("R3");

      // R5 / R12 / R11 / R6: escalation to a forced refresh
      pulse_tick();
      step();
      step();
      pulse_tick();
      chk("R5", "bus_req after second tick", int'(breq), 1);
      chk("R5", "active while waiting", int'(active), 0);
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R5", "bus_req held", int'(breq), 1);
         chk("R5", "no refresh without grant", int'(active), 0);
      end
      strobe(1'b0);
      chk("R12", "no hidden during request", int'(active), 0);
      chk("R12", "bus_req kept", int'(breq), 1);
      ext = 1'b1;
      grant = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R11", "no forced start with ext open", int'(active), 0);
      end
      ext = 1'b0;
      step();
      chk("R6", "forced active", int'(active), 1);
      chk("R6", "forced bus_req", int'(breq), 1);
      for (int c = 1; c <= RC; c++) begin
         step();
         chk("R6", "forced active length", int'(active), (c < RC) ? 1 : 0);
         chk("R6", "bus_req with active", int'(breq), (c < RC) ? 1 : 0);
      end
      grant = 1'b0;
      exp_row = (exp_row + 1) % (1 << RW);
      chk("R7", "row after forced", int'(row), exp_row);

      // R8: extra ticks are dropped
      pulse_tick();
      pulse_tick();
      chk("R8", "escalated", int'(breq), 1);
      pulse_tick();
      pulse_tick();
      grant = 1'b1;
      step();
      chk("R8", "forced started", int'(active), 1);
      grant = 1'b0;
      repeat (RC) step();
      chk("R8", "forced done", int'(active), 0);
      exp_row = (exp_row + 1) % (1 << RW);
      chk("R8", "row after forced", int'(row), exp_row);
      hidden_run("R8");
      strobe(1'b0);
      chk("R8", "no second queued refresh", int'(active), 0);
      chk("R8", "row unchanged", int'(row), exp_row);

      // R9 / R11: timeout sweep over the edge index
      pulse_tick();
      tmo_en = 1'b1;
      ext = 1'b1;
      for (int k = 1; k <= TMO + 3; k++) begin
         if (k == 2) begin
            as_s = 1'b1;
         end
         step();
         as_s = 1'b0;
         chk("R9", "abort timing", int'(abort), (k >= TMO + 1) ? 1 : 0);
         chk("R11", "no hidden with ext open", int'(active), 0);
      end
      ext = 1'b0;
      step();
      chk("R9", "abort clears", int'(abort), 0);
      hidden_run("R9");

      // R10: no abort with nothing owed, or with the timeout disabled
      ext = 1'b1;
      for (int k = 0; k < TMO + 6; k++) begin
         step();
         chk("R10", "abort with nothing owed", int'(abort), 0);
      end
      ext = 1'b0;
      step();
      pulse_tick();
      tmo_en = 1'b0;
      ext = 1'b1;
      for (int k = 0; k < TMO + 6; k++) begin
         step();
         chk("R10", "abort while disabled", int'(abort), 0);
      end
      ext = 1'b0;
      tmo_en = 1'b1;
      step();
      hidden_run("R10");

      // R7: row wrap sweep with varied strobe delay
      for (int i = 0; i < 10; i++) begin
         pulse_tick();
         repeat (i % 4) step();
         hidden_run("R7");
      end

      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run ended)");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule